// File: doc/BRIEF.md
# SR-IOV Virtual Function Routing ID Mapper

This block translates between virtual function indices and 8-bit device/function routing numbers for a single physical function. A forward path turns a VF index into the routing number that VF answers to and says whether that VF currently exists. A reverse path takes the routing number carried by an incoming request and reports whether it addresses an enabled VF, and which one. Both paths follow the usual addressing rule: the first VF sits a fixed offset above the physical function, and each later VF sits a fixed stride above the one before it.

Configuration checks come from the same inputs. One flag is raised when the last VF the function could ever expose would fall past the end of the routing-number space. Another is raised when the first VF would not sit strictly above the physical function. The configuration values are held elsewhere and arrive here as plain inputs. The forward path and the two flags are combinational. The reverse result is registered, so it appears one cycle after the request number is presented.

Top module: `vf_rid_map`

## Requirements
- R1: When `fwd_valid` is high, `fwd_rid` equals `pf_rid + vf_off + fwd_idx * vf_stride`.
- R2: `fwd_valid` is high only when `fwd_idx` is below the active count. The active count is `num_vfs` when `vf_en` is 1 and zero when `vf_en` is 0.
- R3: `fwd_valid` is low whenever `pf_rid + vf_off + fwd_idx * vf_stride`, computed without truncation, is 256 or more.
- R4: `cfg_ovf` is 1 exactly when `total_vfs` is nonzero and `pf_rid + vf_off + (total_vfs - 1) * vf_stride` is 256 or more.
- R5: `cfg_order_err` is 1 exactly when `total_vfs` is nonzero and `vf_off` is 0, because in that case the first VF would not sit above the physical function.
- R6: On the clock edge after `rev_rid` is presented, `rev_valid` and `rev_idx` show the result. `rev_valid` is 1 when some index k below the active count gives `pf_rid + vf_off + k * vf_stride == rev_rid`, and `rev_idx` is then the smallest such k.
- R7: When `vf_stride` is 0, only `rev_rid == pf_rid + vf_off` matches, and it decodes to index 0.
- R8: A `rev_rid` that lies below `pf_rid + vf_off`, that does not fall on a stride step, or that maps to an index at or above the active count gives `rev_valid` = 0. When `vf_en` is 0, no value matches.
- R9: While `rst_n` is low, `rev_valid` and `rev_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_rid | input | 8 | Routing number of the physical function |
| vf_off | input | 8 | Distance from the PF to the first VF |
| vf_stride | input | 8 | Distance between consecutive VFs |
| total_vfs | input | 9 | Largest number of VFs the function can expose |
| num_vfs | input | 9 | Number of VFs currently configured |
| vf_en | input | 1 | VF enable |
| fwd_idx | input | 8 | VF index to translate |
| fwd_rid | output | 8 | Routing number of VF `fwd_idx` |
| fwd_valid | output | 1 | VF `fwd_idx` exists and its number fits in 8 bits |
| rev_rid | input | 8 | Routing number of an incoming request |
| rev_valid | output | 1 | Registered: the request addresses an enabled VF |
| rev_idx | output | 8 | Registered: index of the addressed VF |
| cfg_ovf | output | 1 | The last possible VF would fall past 255 |
| cfg_order_err | output | 1 | The first VF would not sit above the PF |

## Verification
The cross-check between the forward and reverse paths assumes that the PF number, offset, stride, NumVFs and enable stay unchanged over the cycle in which the reverse lookup is registered. The property itself tests that condition and has no effect when it fails. It also assumes that a stride of zero comes with only index 0 in use, which is the one case where the two paths can legitimately disagree. The bench keeps to these assumptions: it changes configuration only on falling edges before a new lookup, and it leaves every setting in place until the registered result has been sampled.

// File: rtl/vf_rid_map.sv
module vf_rid_map #(
  parameter int RID_W = 8,
  parameter int CNT_W = RID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RID_W-1:0] pf_rid,
  input  logic [RID_W-1:0] vf_off,
  input  logic [RID_W-1:0] vf_stride,
  input  logic [CNT_W-1:0] total_vfs,
  input  logic [CNT_W-1:0] num_vfs,
  input  logic             vf_en,
  input  logic [RID_W-1:0] fwd_idx,
  output logic [RID_W-1:0] fwd_rid,
  output logic             fwd_valid,
  input  logic [RID_W-1:0] rev_rid,
  output logic             rev_valid,
  output logic [RID_W-1:0] rev_idx,
  output logic             cfg_ovf,
  output logic             cfg_order_err
);
  localparam int SPAN = 1 << RID_W;
  localparam int WW   = 2 * RID_W + 2;

  logic [CNT_W-1:0] active;
  logic [WW-1:0]    fwd_sum, last_sum, base;
  logic [WW-1:0]    diff;
  logic             above, hit;
  logic [RID_W-1:0] quo;

  assign active = vf_en ? num_vfs : '0;

  assign fwd_sum   = WW'(pf_rid) + WW'(vf_off) + WW'(fwd_idx) * WW'(vf_stride);
  assign fwd_rid   = fwd_sum[RID_W-1:0];
  assign fwd_valid = (CNT_W'(fwd_idx) < active) && (fwd_sum < WW'(SPAN));

  assign last_sum      = WW'(pf_rid) + WW'(vf_off) + (WW'(total_vfs) - WW'(1)) * WW'(vf_stride);
  assign cfg_ovf       = (total_vfs != '0) && (last_sum >= WW'(SPAN));
  assign cfg_order_err = (total_vfs != '0) && (vf_off == '0);

  assign base  = WW'(pf_rid) + WW'(vf_off);
  assign above = WW'(rev_rid) >= base;
  assign diff  = WW'(rev_rid) - base;

  always_comb begin
    hit = 1'b0;
    quo = '0;
    if (above) begin
      for (int k = 0; k < SPAN; k++) begin
        if (!hit && (WW'(k) * WW'(vf_stride) == diff)) begin
          hit = 1'b1;
          quo = RID_W'(k);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rev_valid <= 1'b0;
      rev_idx   <= '0;
    end else begin
      rev_valid <= hit && (CNT_W'(quo) < active);
      rev_idx   <= hit ? quo : '0;
    end
  end

  a_r6_fwd_rev_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && rev_rid == fwd_rid && (vf_stride != '0 || fwd_idx == '0)) |=>
      (!($stable(pf_rid) && $stable(vf_off) && $stable(vf_stride) &&
         $stable(num_vfs) && $stable(vf_en))
       || (rev_valid && rev_idx == $past(fwd_idx))));

  a_r8_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_en |=> !rev_valid);

  a_r2_rev_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid |-> ($past(vf_en) && CNT_W'(rev_idx) < $past(num_vfs)));

  a_r4_no_ovf_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (total_vfs == '0) |-> (!cfg_ovf && !cfg_order_err));

  a_r1_fwd_above_base: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (WW'(fwd_rid) >= WW'(pf_rid) + WW'(vf_off)));

  a_r9_reset_clear: assert property (@(posedge clk)
    !$past(rst_n) |-> (!rev_valid && rev_idx == '0));
endmodule

// File: tb/sim_vf_rid_map.sv
module sim_vf_rid_map;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pf_rid = '0, vf_off = '0, vf_stride = '0, fwd_idx = '0, rev_rid = '0;
  logic [8:0] total_vfs = '0, num_vfs = '0;
  logic       vf_en = 1'b0;
  logic [7:0] fwd_rid, rev_idx;
  logic       fwd_valid, rev_valid, cfg_ovf, cfg_order_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vf_rid_map u0 (
    .clk(clk), .rst_n(rst_n), .pf_rid(pf_rid), .vf_off(vf_off),
    .vf_stride(vf_stride), .total_vfs(total_vfs), .num_vfs(num_vfs),
    .vf_en(vf_en), .fwd_idx(fwd_idx), .fwd_rid(fwd_rid), .fwd_valid(fwd_valid),
    .rev_rid(rev_rid), .rev_valid(rev_valid), .rev_idx(rev_idx),
    .cfg_ovf(cfg_ovf), .cfg_order_err(cfg_order_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic cfg(input int pf, input int off, input int st, input int tot,
                     input int num, input bit en);
    @(negedge clk);
    pf_rid = 8'(pf); vf_off = 8'(off); vf_stride = 8'(st);
    total_vfs = 9'(tot); num_vfs = 9'(num); vf_en = en;
  endtask

  task automatic fwd(input string tag, input int idx, input int exp_rid, input bit exp_v);
    @(negedge clk);
    fwd_idx = 8'(idx);
    #1;
    chk({tag, " valid"}, int'(fwd_valid), int'(exp_v));
    if (exp_v) chk({tag, " rid"}, int'(fwd_rid), exp_rid);
  endtask

  task automatic rev(input string tag, input int rid);
    int act = vf_en ? int'(num_vfs) : 0;
    bit ev = 1'b0;
    int ei = 0;
    for (int k = 0; k < act; k++) begin
      if (!ev && int'(pf_rid) + int'(vf_off) + k * int'(vf_stride) == rid) begin
        ev = 1'b1;
        ei = k;
      end
    end
    @(negedge clk);
    rev_rid = 8'(rid);
    @(posedge clk);
    #1;
    chk({tag, " valid"}, int'(rev_valid), int'(ev));
    if (ev) chk({tag, " idx"}, int'(rev_idx), ei);
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk("R9 reset valid", int'(rev_valid), 0);
    chk("R9 reset idx", int'(rev_idx), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_forward;
    cfg(8, 2, 3, 16, 10, 1'b1);
    fwd("R1 idx0", 0, 10, 1'b1);
    fwd("R1 idx4", 4, 22, 1'b1);
    fwd("R1 idx9", 9, 37, 1'b1);
    fwd("R2 idx at count", 10, 0, 1'b0);
    cfg(8, 2, 3, 16, 10, 1'b0);
    fwd("R2 disabled", 0, 0, 1'b0);
  endtask

  task automatic t_wrap;
    cfg(200, 40, 5, 8, 8, 1'b1);
    fwd("R3 edge 255", 3, 255, 1'b1);
    fwd("R3 past 255", 4, 0, 1'b0);
    #1 chk("R4 ovf set", int'(cfg_ovf), 1);
    cfg(200, 40, 5, 4, 4, 1'b1);
    #1 chk("R4 ovf clear at 255", int'(cfg_ovf), 0);
    cfg(200, 40, 5, 0, 0, 1'b1);
    #1 chk("R4 ovf empty", int'(cfg_ovf), 0);
  endtask

  task automatic t_order;
    cfg(4, 0, 1, 2, 2, 1'b1);
    #1 chk("R5 zero offset", int'(cfg_order_err), 1);
    cfg(4, 1, 1, 2, 2, 1'b1);
    #1 chk("R5 nonzero offset", int'(cfg_order_err), 0);
  endtask

  task automatic t_reverse;
    cfg(8, 2, 3, 16, 10, 1'b1);
    rev("R6 first", 10);
    rev("R6 mid", 19);
    rev("R6 last", 37);
    rev("R8 beyond count", 40);
    rev("R8 off step", 11);
    rev("R8 below base", 5);
    cfg(8, 2, 3, 16, 10, 1'b0);
    rev("R8 disabled", 10);
  endtask

  task automatic t_stride0;
    cfg(30, 6, 0, 1, 1, 1'b1);
    fwd("R7 fwd idx0", 0, 36, 1'b1);
    rev("R7 exact", 36);
    rev("R7 next", 37);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_forward();
    t_wrap();
    t_order();
    t_reverse();
    t_stride0();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule